// File: doc/BRIEF.md
# DMA Request Line to Channel Router

This block sits between a set of peripheral DMA request lines and the channels of a DMA engine. Each request line owns a small mapping entry that holds a valid flag and a target channel number. Every cycle, each channel's request output is registered as the OR of all request lines whose entry is valid and names that channel. A line whose entry is not valid drives nothing.

The same block gathers the per-channel interrupt lines. It presents them as a read-only summary word, as one combined interrupt, and as one pending flag per priority group. A group is a run of four consecutive channel numbers, and the grouping repeats every sixteen channels. Software programs the mapping entries through a simple word-addressed register port. Reads return data one cycle after the read strobe.

The mapping entries sit in two address windows of 64 entries each. The window is chosen by whether the line number is below 64.

Top module: `dma_req_mapper`

## Requirements
- R1: After a synchronous reset, all mapping entries read as zero, and `ch_req`, `grp_irq`, `irq_out`, `reg_rdata` and `reg_rvalid` are all zero.
- R2: The mapping entry of request line n, for n < 64, is at byte offset 0x0100 + 4*n. A write followed by a read at that offset returns the stored entry.
- R3: The mapping entry of request line n, for 64 <= n < 128, is at byte offset 0x1100 + 4*(n-64). A write followed by a read returns the stored entry.
- R4: A mapping entry keeps only bit 7 (valid) and bits 4:0 (channel number). Every other bit of the entry reads as zero, whatever was written.
- R5: One clock after `req_in` is sampled, `ch_req[c]` is the OR of `req_in[n]` over every line n whose entry is valid and has channel number c.
- R6: A line whose valid bit is clear drives no channel, whatever its channel bits hold. Writing zero to an entry detaches its line from every channel.
- R7: The summary register at byte offset 0x00F0 reads with bit i equal to `ch_irq_in[i]` as registered one cycle earlier. Writes to it have no effect.
- R8: `irq_out` is high in the cycle after any bit of `ch_irq_in` is high, and low in the cycle after all bits are low.
- R9: `grp_irq[g]` is high in the cycle after any channel i with (i mod 16)/4 == g has `ch_irq_in[i]` high.
- R10: Reads from any other offset return zero, and writes there change no entry. This covers misaligned offsets and entries of lines at or above NUM_REQ.
- R11: `reg_rvalid` pulses in the cycle after `reg_rd`, with the read data in `reg_rdata`. In any cycle not following a read, both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, one cycle after `reg_rd` |
| reg_rvalid | output | 1 | Read data valid |
| req_in | input | NUM_REQ | Peripheral request lines |
| ch_irq_in | input | NUM_CH | Per-channel interrupt lines |
| ch_req | output | NUM_CH | Registered per-channel requests |
| grp_irq | output | 4 | Registered per-priority-group pending flags |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
The bench builds the block with NUM_REQ = 72 and a full 32 channels. This puts eight lines in the upper window and leaves the rest of that window unimplemented, so both window decodes are covered, along with the gap above the last line. With 72 lines, every entry can be written and read back, and each line can be routed on its own. Every channel number can be made the target, and every single-channel interrupt can be walked through the summary and group outputs. Expected routes and group flags are computed from a model table kept in the bench.

// File: rtl/reqmap_pkg.sv
package reqmap_pkg;
  localparam int CH_W      = 5;
  localparam int IDX_W     = 7;
  localparam int WIN_LINES = 64;
  localparam int VLD_POS   = 7;
  localparam int GRP_SPAN  = 4;
  localparam int GRP_WRAP  = 16;
  localparam int NUM_GRP   = GRP_WRAP / GRP_SPAN;

  localparam logic [31:0] SUM_OFS = 32'h0000_00F0;
  localparam logic [31:0] LO_BASE = 32'h0000_0100;
  localparam logic [31:0] HI_BASE = 32'h0000_1100;

  typedef struct packed {
    logic            vld;
    logic [CH_W-1:0] ch;
  } map_ent_t;

  function automatic int grp_of(input int chan);
    return (chan % GRP_WRAP) / GRP_SPAN;
  endfunction
endpackage

// File: rtl/reqmap_decode.sv
module reqmap_decode
  import reqmap_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_REQ = 96
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_sum,
  output logic              hit_map,
  output logic [IDX_W-1:0]  map_idx
);
  localparam logic [31:0] WIN_BYTES = 32'(WIN_LINES * 4);

  logic [31:0] a32;
  logic        aligned;
  logic        in_lo;
  logic        in_hi;

  always_comb begin
    a32     = 32'(addr);
    aligned = (a32[1:0] == 2'b00);
    in_lo   = (a32 >= LO_BASE) && (a32 < LO_BASE + WIN_BYTES);
    in_hi   = (a32 >= HI_BASE) && (a32 < HI_BASE + WIN_BYTES);
    // upper window lines are 64 + slot, so the window flag is the index MSB
    map_idx = {in_hi, a32[7:2]};
    hit_map = aligned && (in_lo || in_hi) && (int'(map_idx) < NUM_REQ);
    hit_sum = (a32 == SUM_OFS);
  end
endmodule

// File: rtl/reqmap_regs.sv
module reqmap_regs
  import reqmap_pkg::*;
#(
  parameter int NUM_REQ = 96
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  map_ent_t                 wr_ent,
  output map_ent_t [NUM_REQ-1:0]   maps
);
  for (genvar r = 0; r < NUM_REQ; r++) begin : g_line
    map_ent_t ent_q;
    always_ff @(posedge clk) begin
      if (rst)                                  ent_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(r))    ent_q <= wr_ent;
    end
    assign maps[r] = ent_q;
  end
endmodule

// File: rtl/reqmap_router.sv
module reqmap_router
  import reqmap_pkg::*;
#(
  parameter int NUM_REQ = 96,
  parameter int NUM_CH  = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  map_ent_t [NUM_REQ-1:0] maps,
  input  logic [NUM_REQ-1:0]     req_in,
  output logic [NUM_CH-1:0]      ch_req
);
  logic [NUM_CH-1:0] req_d;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int r = 0; r < NUM_REQ; r++) begin
        if (req_in[r] && maps[r].vld && maps[r].ch == CH_W'(c)) hit = 1'b1;
      end
    end
    assign req_d[c] = hit;
  end

  always_ff @(posedge clk) begin
    if (rst) ch_req <= '0;
    else     ch_req <= req_d;
  end
endmodule

// File: rtl/reqmap_irq.sv
module reqmap_irq
  import reqmap_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CH-1:0]  ch_irq,
  output logic [NUM_CH-1:0]  sum_q,
  output logic               any_q,
  output logic [NUM_GRP-1:0] grp_q
);
  logic [NUM_GRP-1:0] grp_d;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
        if (grp_of(i) == g) acc = acc | ch_irq[i];
      end
    end
    assign grp_d[g] = acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      any_q <= 1'b0;
      grp_q <= '0;
    end else begin
      sum_q <= ch_irq;
      any_q <= |ch_irq;
      grp_q <= grp_d;
    end
  end
endmodule

// File: rtl/dma_req_mapper.sv
module dma_req_mapper
  import reqmap_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int NUM_REQ = 96,
  parameter int NUM_CH  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               reg_rvalid,
  input  logic [NUM_REQ-1:0] req_in,
  input  logic [NUM_CH-1:0]  ch_irq_in,
  output logic [NUM_CH-1:0]  ch_req,
  output logic [NUM_GRP-1:0] grp_irq,
  output logic               irq_out
);
  logic                   hit_sum;
  logic                   hit_map;
  logic [IDX_W-1:0]       map_idx;
  map_ent_t [NUM_REQ-1:0] maps;
  map_ent_t               wr_ent;
  map_ent_t               rd_ent;
  logic [NUM_CH-1:0]      irq_sum;
  logic [DATA_W-1:0]      rd_d;
  logic                   unused_wdata;

  assign unused_wdata = ^{reg_wdata[DATA_W-1:VLD_POS+1], reg_wdata[VLD_POS-1:CH_W]};

  reqmap_decode #(.ADDR_W(ADDR_W), .NUM_REQ(NUM_REQ)) dec_i (
    .addr    (reg_addr),
    .hit_sum (hit_sum),
    .hit_map (hit_map),
    .map_idx (map_idx)
  );

  assign wr_ent = '{vld: reg_wdata[VLD_POS], ch: reg_wdata[CH_W-1:0]};

  reqmap_regs #(.NUM_REQ(NUM_REQ)) regs_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr && hit_map),
    .wr_idx (map_idx),
    .wr_ent (wr_ent),
    .maps   (maps)
  );

  reqmap_router #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) route_i (
    .clk    (clk),
    .rst    (rst),
    .maps   (maps),
    .req_in (req_in),
    .ch_req (ch_req)
  );

  reqmap_irq #(.NUM_CH(NUM_CH)) irq_i (
    .clk    (clk),
    .rst    (rst),
    .ch_irq (ch_irq_in),
    .sum_q  (irq_sum),
    .any_q  (irq_out),
    .grp_q  (grp_irq)
  );

  always_comb begin
    rd_ent = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      if (map_idx == IDX_W'(r)) rd_ent = maps[r];
    end
  end

  always_comb begin
    rd_d = '0;
    if (hit_sum) begin
      rd_d = DATA_W'(irq_sum);
    end else if (hit_map) begin
      rd_d[VLD_POS]    = rd_ent.vld;
      rd_d[CH_W-1:0]   = rd_ent.ch;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rdata  <= reg_rd ? rd_d : '0;
      reg_rvalid <= reg_rd;
    end
  end
endmodule

// File: rtl/reqmap_chk.sv
module reqmap_chk #(
  parameter int DATA_W  = 32,
  parameter int NUM_REQ = 96,
  parameter int NUM_CH  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_rd,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               reg_rvalid,
  input logic [NUM_REQ-1:0] req_in,
  input logic [NUM_CH-1:0]  ch_irq_in,
  input logic [NUM_CH-1:0]  ch_req,
  input logic [3:0]         grp_irq,
  input logic               irq_out
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (ch_req == '0 && !irq_out && grp_irq == '0 && !reg_rvalid && reg_rdata == '0));

  assert_idle_lines_R5: assert property (@(posedge clk) disable iff (rst)
    (req_in == '0) |=> (ch_req == '0));

  assert_fanout_bound_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(ch_req) <= $countones($past(req_in)));

  assert_irq_any_R8: assert property (@(posedge clk) disable iff (rst)
    (ch_irq_in != '0) |=> irq_out);

  assert_irq_none_R8: assert property (@(posedge clk) disable iff (rst)
    (ch_irq_in == '0) |=> !irq_out);

  assert_grp_none_R9: assert property (@(posedge clk) disable iff (rst)
    (ch_irq_in == '0) |=> (grp_irq == '0));

  assert_grp_some_R9: assert property (@(posedge clk) disable iff (rst)
    (ch_irq_in != '0) |=> (grp_irq != '0));

  assert_rd_valid_R11: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);

  assert_rd_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (!reg_rvalid && reg_rdata == '0));
endmodule

bind dma_req_mapper reqmap_chk #(
  .DATA_W (DATA_W),
  .NUM_REQ(NUM_REQ),
  .NUM_CH (NUM_CH)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .reg_rd    (reg_rd),
  .reg_rdata (reg_rdata),
  .reg_rvalid(reg_rvalid),
  .req_in    (req_in),
  .ch_irq_in (ch_irq_in),
  .ch_req    (ch_req),
  .grp_irq   (grp_irq),
  .irq_out   (irq_out)
);

// File: tb/dma_req_mapper_tb_top.sv
module dma_req_mapper_tb_top;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int NUM_REQ = 72;
  localparam int NUM_CH  = 32;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               reg_wr = 1'b0;
  logic               reg_rd = 1'b0;
  logic [ADDR_W-1:0]  reg_addr = '0;
  logic [DATA_W-1:0]  reg_wdata = '0;
  logic [DATA_W-1:0]  reg_rdata;
  logic               reg_rvalid;
  logic [NUM_REQ-1:0] req_in = '0;
  logic [NUM_CH-1:0]  ch_irq_in = '0;
  logic [NUM_CH-1:0]  ch_req;
  logic [3:0]         grp_irq;
  logic               irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic       m_vld [NUM_REQ];
  logic [4:0] m_ch  [NUM_REQ];

  always #10 clk = ~clk;

  dma_req_mapper #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .req_in(req_in), .ch_irq_in(ch_irq_in), .ch_req(ch_req), .grp_irq(grp_irq),
    .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] addr_of(input int n);
    if (n < 64) return 16'(32'h100 + 4 * n);
    return 16'(32'h1100 + 4 * (n - 64));
  endfunction

  function automatic logic [31:0] route(input logic [NUM_REQ-1:0] rq);
    logic [31:0] o = '0;
    for (int n = 0; n < NUM_REQ; n++)
      if (rq[n] && m_vld[n]) o[m_ch[n]] = 1'b1;
    return o;
  endfunction

  function automatic logic [3:0] grp_exp(input logic [31:0] v);
    logic [3:0] g = '0;
    for (int i = 0; i < 32; i++)
      if (v[i]) g[(i % 16) / 4] = 1'b1;
    return g;
  endfunction

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
    chk("R11 rvalid after read", 32'(reg_rvalid), 32'd1);
  endtask

  task automatic set_map(input int n, input logic v, input logic [4:0] c);
    m_vld[n] = v; m_ch[n] = c;
    wr(addr_of(n), {24'h0, v, 2'b00, c});
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] s;
    for (int n = 0; n < NUM_REQ; n++) begin m_vld[n] = 1'b0; m_ch[n] = '0; end

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 ch_req", ch_req, 32'h0);
    chk("R1 irq_out", 32'(irq_out), 32'h0);
    chk("R1 grp_irq", 32'(grp_irq), 32'h0);
    chk("R1 rvalid", 32'(reg_rvalid), 32'h0);
    rd(addr_of(0), d);  chk("R1 entry 0", d, 32'h0);
    rd(addr_of(63), d); chk("R1 entry 63", d, 32'h0);
    rd(addr_of(71), d); chk("R1 entry 71", d, 32'h0);

    // R2 R3 R4: write every entry with junk in the unused bits
    for (int n = 0; n < NUM_REQ; n++) begin
      m_vld[n] = (n % 3) != 0;
      m_ch[n]  = 5'((n * 7 + 3) % 32);
      wr(addr_of(n), 32'hDEAD_BE60 | (32'(m_vld[n]) << 7) | 32'(m_ch[n]));
    end
    for (int n = 0; n < NUM_REQ; n++) begin
      rd(addr_of(n), d);
      chk(n < 64 ? "R2 R4 lower window readback" : "R3 R4 upper window readback",
          d, (32'(m_vld[n]) << 7) | 32'(m_ch[n]));
    end
    @(negedge clk);
    chk("R11 rdata idle", reg_rdata, 32'h0);
    chk("R11 rvalid idle", 32'(reg_rvalid), 32'h0);

    // R5 R6: each line alone
    for (int n = 0; n < NUM_REQ; n++) begin
      req_in = '0; req_in[n] = 1'b1;
      @(negedge clk);
      chk(m_vld[n] ? "R5 single line route" : "R6 invalid line silent", ch_req, route(req_in));
    end
    req_in = '1;
    @(negedge clk);
    chk("R5 all lines", ch_req, route(req_in));
    s = 32'h1234_5678;
    for (int k = 0; k < 24; k++) begin
      logic [95:0] w;
      for (int j = 0; j < 3; j++) begin
        s ^= s << 13; s ^= s >> 17; s ^= s << 5;
        w[j*32 +: 32] = s;
      end
      req_in = w[NUM_REQ-1:0];
      @(negedge clk);
      chk("R5 mixed lines", ch_req, route(req_in));
    end

    // R5: every channel number as a target
    for (int c = 0; c < 32; c++) begin
      req_in = '0;
      set_map(5, 1'b1, 5'(c));
      req_in[5] = 1'b1;
      @(negedge clk);
      chk("R5 channel sweep", ch_req, 32'h1 << c);
    end

    // R6: detach by writing zero
    set_map(66, 1'b1, 5'd9);
    req_in = '0; req_in[66] = 1'b1; req_in[5] = 1'b1;
    @(negedge clk);
    chk("R5 before detach", ch_req, route(req_in));
    m_vld[5] = 1'b0; m_ch[5] = '0; wr(addr_of(5), 32'h0);
    m_vld[66] = 1'b0; m_ch[66] = '0; wr(addr_of(66), 32'h0);
    @(negedge clk);
    chk("R6 detached lines", ch_req, 32'h0);
    rd(addr_of(66), d); chk("R6 detached readback", d, 32'h0);
    req_in = '0;

    // R7 R8 R9: walk single interrupts
    for (int i = 0; i < 32; i++) begin
      ch_irq_in = 32'h1 << i;
      @(negedge clk);
      chk("R8 irq_out single", 32'(irq_out), 32'h1);
      chk("R9 group single", 32'(grp_irq), 32'(grp_exp(ch_irq_in)));
      rd(16'h00F0, d);
      chk("R7 summary single", d, ch_irq_in);
    end
    ch_irq_in = '0;
    @(negedge clk);
    chk("R8 irq_out clear", 32'(irq_out), 32'h0);
    chk("R9 group clear", 32'(grp_irq), 32'h0);
    for (int k = 0; k < 4; k++) begin
      ch_irq_in = (k == 0) ? 32'hFFFF_0000 : (k == 1) ? 32'h0000_1000 :
                  (k == 2) ? 32'h0042_0000 : 32'h8000_0001;
      @(negedge clk);
      chk("R9 group pattern", 32'(grp_irq), 32'(grp_exp(ch_irq_in)));
      chk("R8 irq_out pattern", 32'(irq_out), 32'h1);
    end
    ch_irq_in = 32'h0000_0005;
    wr(16'h00F0, 32'hFFFF_FFFF);
    rd(16'h00F0, d);
    chk("R7 summary write ignored", d, 32'h0000_0005);
    ch_irq_in = '0;

    // R10: unimplemented offsets
    for (int k = 0; k < 11; k++) begin
      logic [15:0] a;
      case (k)
        0: a = 16'h0000;  1: a = 16'h00EC;  2: a = 16'h00F4;  3: a = 16'h0101;
        4: a = 16'h0102;  5: a = 16'h00FC;  6: a = 16'h0200;  7: a = 16'h1120;
        8: a = 16'h11FC;  9: a = 16'h1000;  default: a = 16'h00F2;
      endcase
      wr(a, 32'hFFFF_FFFF);
      rd(a, d);
      chk("R10 unimplemented reads zero", d, 32'h0);
    end
    for (int n = 0; n < NUM_REQ; n++) begin
      rd(addr_of(n), d);
      chk("R10 entries untouched", d, (32'(m_vld[n]) << 7) | 32'(m_ch[n]));
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1..R11 actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule